// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level page table out of memory through a plain 32-bit read/write port that carries one request at a time. At each table level it compares the entry's protection field with the access level the request needs. It also writes the referenced bit back into the entry, and the modified bit as well when the access is a write. Each request arrives with a user/supervisor flag, a write flag, a 4-bit bus status code, a debug flag and a validate flag. Control inputs switch translation on or off separately for user and supervisor accesses, select a separate table base for user accesses, and override the access level.

The walk ends with a one-cycle `done` pulse that carries the result: complete, abort or cancel. Cancel is the outcome reserved for validate requests. When a normal walk faults, the block writes the cause into an 8-bit status register and loads the faulting virtual address into an exception-address register. A debug walk returns the same result as a normal walk but leaves memory and both of those registers untouched.

Top module: `pgwalk_top`

## Requirements
- R1: When translation is disabled for the access mode (`cfg_xlate_user` clear for a user access, `cfg_xlate_sup` clear for a supervisor access), the walker makes no memory access. It raises `done` on the cycle after acceptance with `pa` equal to the virtual address and result complete (code 0). The status and exception-address registers are left unchanged.
- R2: The first-level base is `cfg_base1` for a user access while `cfg_dual` is set; otherwise it is `cfg_base0`. The low 12 bits of the selected base are ignored. The first-level entry address is the base OR (VA[31:22] shifted left by 2).
- R3: The second-level entry address is first-level entry bits 31:12, followed by 12 zero bits, OR (VA[21:12] shifted left by 2). On success `pa` is second-level entry bits 31:12 concatenated with VA[11:0], and the result is complete (code 0).
- R4: The required level (0 to 3) is compared with entry bits 2:1. A user access without `cfg_override` needs level 3 for a write and level 2 for a read. Any other access needs level 1 for a write and level 0 for a read. A request counts as a write when `req_write` is set or when the bus status code is 4'hB.
- R5: An entry faults when the required level exceeds its bits 2:1, or when bit 0 (valid) is clear. The exception code is 3 for a protection fault, which takes priority over an invalid entry. Otherwise it is 1 at the first level and 2 at the second. A fault on a walk that is not a validate gives result abort (code 1).
- R6: On a fault in a normal walk (neither debug nor validate), the status register is loaded with {bus status code, user flag, `req_write`, exception code}, from bit 7 down to bit 0. The exception-address register is loaded with the virtual address.
- R7: A normal walk with translation enabled clears the status register when it is accepted. The exception-address register keeps its value unless a fault occurs.
- R8: A first-level entry that passes with bit 7 (referenced) clear is written back with bit 7 set. A faulting entry is never written.
- R9: A second-level entry that passes is written back with bit 7 set, and with bit 8 (modified) set when `req_write` is set, whenever either bit has to change. Otherwise it is not written.
- R10: In a validate walk, a first-level fault on a valid entry, or any second-level fault, gives result cancel (code 2). A first-level fault on an invalid entry gives abort. The status and exception-address registers are not touched.
- R11: A debug walk produces the same result and address as a normal walk. It writes no entry and leaves the status and exception-address registers unchanged.
- R12: While `mem_valid` is high and `mem_ready` is low, the request (`mem_valid`, `mem_we`, `mem_addr`) is held on the next cycle.
- R13: After reset the walker is idle, `done` and `mem_valid` are low, and the status and exception-address registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk; taken while `busy` is low |
| req_va | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user access, 0 = supervisor |
| req_write | input | 1 | Write access |
| req_bstat | input | 4 | Bus status code of the access |
| req_debug | input | 1 | Walk with no side effects |
| req_validate | input | 1 | Walk performed for a validate command |
| cfg_xlate_user | input | 1 | Translate user accesses |
| cfg_xlate_sup | input | 1 | Translate supervisor accesses |
| cfg_dual | input | 1 | Use the second table base for user accesses |
| cfg_override | input | 1 | Check user accesses at supervisor level |
| cfg_base0 | input | 32 | First table base |
| cfg_base1 | input | 32 | Second table base |
| busy | output | 1 | Walk in progress (includes the done cycle) |
| done | output | 1 | One-cycle pulse ending a walk |
| result | output | 2 | 0 complete, 1 abort, 2 cancel; valid with `done` |
| pa | output | 32 | Physical address; valid with `done` on complete |
| mem_valid | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request; read data valid |
| mem_rdata | input | 32 | Read data |
| stat_msr | output | 8 | Fault status register |
| stat_tear | output | 32 | Exception address register |

## Verification
Seeded random walks draw the mode, the enables, the dual-base and override settings, write flags and bus codes, and every entry field. The memory model stalls `mem_ready` at random, so the handshake hold is tested at every request phase. Directed cases then separate the pairs that random stimulus rarely pulls apart. The two table bases are told apart by giving the same virtual address different frames under each base. Protection priority is checked on entries that are both invalid and under-privileged, and the first-level and second-level invalid codes are checked on their own. The bus-code-as-write rule is separated from the recorded write flag, write-back is tested against an entry that already has its bits set, and the validate and debug modes are checked against the normal outcome of the same tables.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    RES_COMPLETE = 2'd0,
    RES_ABORT    = 2'd1,
    RES_CANCEL   = 2'd2
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1RD,
    ST_L1WB,
    ST_L2RD,
    ST_L2WB,
    ST_DONE
  } st_e;

  // entry field positions
  localparam int unsigned PTE_V = 0;
  localparam int unsigned PTE_R = 7;
  localparam int unsigned PTE_M = 8;

  // bus status code of a read-modify-write operand
  localparam logic [3:0] BS_RMW = 4'hB;

endpackage

// File: rtl/pgwalk_mode.sv
module pgwalk_mode #(
  parameter int AW     = 32,
  parameter int PAGE_W = 12
) (
  input  logic          user,
  input  logic          write,
  input  logic [3:0]    bstat,
  input  logic          en_user,
  input  logic          en_sup,
  input  logic          dual,
  input  logic          override,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  output logic          bypass,
  output logic [AW-1:0] base,
  output logic [1:0]    need
);
  import pgwalk_pkg::*;

  localparam logic [AW-1:0] PAGE_MASK = {{(AW-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};

  logic wr_eff;

  always_comb begin
    bypass = user ? !en_user : !en_sup;
    base   = ((dual && user) ? base1 : base0) & PAGE_MASK;
    wr_eff = write || (bstat == BS_RMW);
    need   = {user && !override, wr_eff};
  end

endmodule

// File: rtl/pgwalk_pte_chk.sv
module pgwalk_pte_chk #(
  parameter int         AW       = 32,
  parameter logic [1:0] INV_CODE = 2'd1
) (
  input  logic [AW-1:0] pte,
  input  logic [1:0]    need,
  output logic          fault,
  output logic [1:0]    code
);
  import pgwalk_pkg::*;

  logic prot;

  always_comb begin
    prot  = need > pte[2:1];
    fault = prot || !pte[PTE_V];
    code  = prot ? 2'd3 : INV_CODE;
  end

endmodule

// File: rtl/pgwalk_status.sv
module pgwalk_status #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rec,
  input  logic [7:0]    rec_msr,
  input  logic [AW-1:0] rec_va,
  output logic [7:0]    msr,
  output logic [AW-1:0] tear
);

  logic          msr_en;
  logic [7:0]    msr_d;

  always_comb begin
    msr_en = clr || rec;
    msr_d  = rec ? rec_msr : 8'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msr  <= 8'd0;
      tear <= '0;
    end else begin
      if (msr_en) msr  <= msr_d;
      if (rec)    tear <= rec_va;
    end
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 10,
  localparam int AW    = PAGE_W + 2 * IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_va,
  input  logic          req_user,
  input  logic          req_write,
  input  logic [3:0]    req_bstat,
  input  logic          req_debug,
  input  logic          req_validate,
  input  logic          cfg_xlate_user,
  input  logic          cfg_xlate_sup,
  input  logic          cfg_dual,
  input  logic          cfg_override,
  input  logic [AW-1:0] cfg_base0,
  input  logic [AW-1:0] cfg_base1,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic [AW-1:0] pa,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [AW-1:0] mem_rdata,
  output logic [7:0]    stat_msr,
  output logic [AW-1:0] stat_tear
);
  import pgwalk_pkg::*;

  localparam int NLVL = 2;
  localparam logic [AW-1:0] R_BIT = AW'(1) << PTE_R;
  localparam logic [AW-1:0] M_BIT = AW'(1) << PTE_M;

  // decoded request
  logic          m_bypass;
  logic [AW-1:0] m_base;
  logic [1:0]    m_need;

  // walk state
  st_e           st_q, st_d;
  res_e          res_q, res_d;
  logic [AW-1:0] va_q, va_d, base_q, base_d, pa_q, pa_d;
  logic [AW-1:0] pte1_q, pte1_d, pte2_q, pte2_d;
  logic [1:0]    need_q, need_d;
  logic [3:0]    bs_q, bs_d;
  logic          user_q, user_d, wr_q, wr_d, dbg_q, dbg_d, vld_q, vld_d;

  // status control
  logic          s_clr, s_rec;
  logic [1:0]    s_code;

  // per-level entry checks
  logic [NLVL-1:0] lv_fault;
  logic [1:0]      lv_code [NLVL];

  logic [AW-1:0] l1_addr, l2_addr;

  pgwalk_mode #(.AW(AW), .PAGE_W(PAGE_W)) u_mode (
    .user     (req_user),
    .write    (req_write),
    .bstat    (req_bstat),
    .en_user  (cfg_xlate_user),
    .en_sup   (cfg_xlate_sup),
    .dual     (cfg_dual),
    .override (cfg_override),
    .base0    (cfg_base0),
    .base1    (cfg_base1),
    .bypass   (m_bypass),
    .base     (m_base),
    .need     (m_need)
  );

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    pgwalk_pte_chk #(.AW(AW), .INV_CODE(2'(g + 1))) u_chk (
      .pte   (mem_rdata),
      .need  (need_q),
      .fault (lv_fault[g]),
      .code  (lv_code[g])
    );
  end

  pgwalk_status #(.AW(AW)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (s_clr),
    .rec     (s_rec),
    .rec_msr ({bs_q, user_q, wr_q, s_code}),
    .rec_va  (va_q),
    .msr     (stat_msr),
    .tear    (stat_tear)
  );

  // table entry addresses
  always_comb begin
    l1_addr = base_q | AW'({va_q[AW-1 -: IDX_W], 2'b00});
    l2_addr = {pte1_q[AW-1:PAGE_W], {PAGE_W{1'b0}}} | AW'({va_q[PAGE_W +: IDX_W], 2'b00});
  end

  // memory port
  always_comb begin
    mem_valid = (st_q == ST_L1RD) || (st_q == ST_L1WB) || (st_q == ST_L2RD) || (st_q == ST_L2WB);
    mem_we    = (st_q == ST_L1WB) || (st_q == ST_L2WB);
    mem_addr  = ((st_q == ST_L1RD) || (st_q == ST_L1WB)) ? l1_addr : l2_addr;
    mem_wdata = (st_q == ST_L1WB) ? (pte1_q | R_BIT)
                                  : (pte2_q | R_BIT | (wr_q ? M_BIT : '0));
  end

  // next state
  always_comb begin
    st_d   = st_q;   res_d  = res_q;
    va_d   = va_q;   base_d = base_q; pa_d = pa_q;
    pte1_d = pte1_q; pte2_d = pte2_q;
    need_d = need_q; bs_d   = bs_q;
    user_d = user_q; wr_d   = wr_q;   dbg_d = dbg_q; vld_d = vld_q;
    s_clr  = 1'b0;   s_rec  = 1'b0;   s_code = 2'd0;

    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          va_d   = req_va;    user_d = req_user;  wr_d  = req_write;
          bs_d   = req_bstat; dbg_d  = req_debug; vld_d = req_validate;
          need_d = m_need;    base_d = m_base;
          if (m_bypass) begin
            pa_d  = req_va;
            res_d = RES_COMPLETE;
            st_d  = ST_DONE;
          end else begin
            s_clr = !req_debug && !req_validate;
            st_d  = ST_L1RD;
          end
        end
      end
      ST_L1RD: begin
        if (mem_ready) begin
          pte1_d = mem_rdata;
          if (lv_fault[0]) begin
            res_d  = (vld_q && mem_rdata[PTE_V]) ? RES_CANCEL : RES_ABORT;
            s_rec  = !dbg_q && !vld_q;
            s_code = lv_code[0];
            st_d   = ST_DONE;
          end else if (!mem_rdata[PTE_R] && !dbg_q) begin
            st_d = ST_L1WB;
          end else begin
            st_d = ST_L2RD;
          end
        end
      end
      ST_L1WB: begin
        if (mem_ready) st_d = ST_L2RD;
      end
      ST_L2RD: begin
        if (mem_ready) begin
          pte2_d = mem_rdata;
          if (lv_fault[1]) begin
            res_d  = vld_q ? RES_CANCEL : RES_ABORT;
            s_rec  = !dbg_q && !vld_q;
            s_code = lv_code[1];
            st_d   = ST_DONE;
          end else begin
            pa_d  = {mem_rdata[AW-1:PAGE_W], va_q[PAGE_W-1:0]};
            res_d = RES_COMPLETE;
            if (!dbg_q && (!mem_rdata[PTE_R] || (wr_q && !mem_rdata[PTE_M])))
              st_d = ST_L2WB;
            else
              st_d = ST_DONE;
          end
        end
      end
      ST_L2WB: begin
        if (mem_ready) st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;  res_q  <= RES_COMPLETE;
      va_q   <= '0;       base_q <= '0;  pa_q <= '0;
      pte1_q <= '0;       pte2_q <= '0;
      need_q <= 2'd0;     bs_q   <= 4'd0;
      user_q <= 1'b0;     wr_q   <= 1'b0; dbg_q <= 1'b0; vld_q <= 1'b0;
    end else begin
      st_q   <= st_d;     res_q  <= res_d;
      va_q   <= va_d;     base_q <= base_d; pa_q <= pa_d;
      pte1_q <= pte1_d;   pte2_q <= pte2_d;
      need_q <= need_d;   bs_q   <= bs_d;
      user_q <= user_d;   wr_q   <= wr_d;   dbg_q <= dbg_d; vld_q <= vld_d;
    end
  end

  always_comb begin
    busy   = (st_q != ST_IDLE);
    done   = (st_q == ST_DONE);
    result = res_q;
    pa     = pa_q;
  end

endmodule

// File: rtl/pgwalk_sva.sv
module pgwalk_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_va,
  input logic          req_user,
  input logic          req_debug,
  input logic          req_validate,
  input logic          cfg_xlate_user,
  input logic          cfg_xlate_sup,
  input logic          busy,
  input logic          done,
  input logic [1:0]    result,
  input logic [AW-1:0] pa,
  input logic          mem_valid,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic [7:0]    stat_msr,
  input logic [AW-1:0] stat_tear
);

  logic accept, off;
  logic dbg_s, vld_s;

  always_comb begin
    accept = req_valid && !busy;
    off    = req_user ? !cfg_xlate_user : !cfg_xlate_sup;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_s <= 1'b0;
      vld_s <= 1'b0;
    end else if (accept) begin
      dbg_s <= req_debug;
      vld_s <= req_validate;
    end
  end

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && off) |=> (done && result == 2'd0 && pa == $past(req_va))); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we))); // R12

  AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> mem_wdata[7]); // R8

  AST_DEBUG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dbg_s) |-> !(mem_valid && mem_we)); // R11

  AST_DEBUG_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dbg_s) |=> ($stable(stat_msr) && $stable(stat_tear))); // R11

  AST_VALIDATE_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && vld_s) |=> ($stable(stat_msr) && $stable(stat_tear))); // R10

  AST_CANCEL_ONLY_VALIDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd2) |-> vld_s); // R10

  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'd3)); // R5

  AST_NORMAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !off && !req_debug && !req_validate) |=> (stat_msr == 8'd0)); // R7

endmodule

bind pgwalk_top pgwalk_sva #(.AW(AW)) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_va         (req_va),
  .req_user       (req_user),
  .req_debug      (req_debug),
  .req_validate   (req_validate),
  .cfg_xlate_user (cfg_xlate_user),
  .cfg_xlate_sup  (cfg_xlate_sup),
  .busy           (busy),
  .done           (done),
  .result         (result),
  .pa             (pa),
  .mem_valid      (mem_valid),
  .mem_we         (mem_we),
  .mem_addr       (mem_addr),
  .mem_wdata      (mem_wdata),
  .mem_ready      (mem_ready),
  .stat_msr       (stat_msr),
  .stat_tear      (stat_tear)
);

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE_A = 32'h0000_1000;
  localparam logic [31:0] BASE_B = 32'h0000_3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_user, req_write, req_debug, req_validate;
  logic [31:0] req_va;
  logic [3:0]  req_bstat;
  logic        en_user, en_sup, dual, ovr;
  logic [31:0] base0, base1;
  logic        busy, done, mem_valid, mem_we, mem_ready;
  logic [1:0]  result;
  logic [31:0] pa, mem_addr, mem_wdata, mem_rdata, tear;
  logic [7:0]  msr;

  logic [31:0] mem [logic [31:0]];

  int n_chk = 0, n_fail = 0;
  int hs_cnt = 0, wr_cnt = 0, viol = 0;
  logic [7:0]  exp_msr;
  logic [31:0] exp_tear;
  logic        pend;
  logic [31:0] pend_addr;
  logic        pend_we;
  bit          finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pgwalk_top uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_va(req_va), .req_user(req_user), .req_write(req_write),
    .req_bstat(req_bstat), .req_debug(req_debug), .req_validate(req_validate),
    .cfg_xlate_user(en_user), .cfg_xlate_sup(en_sup), .cfg_dual(dual), .cfg_override(ovr),
    .cfg_base0(base0), .cfg_base1(base1),
    .busy(busy), .done(done), .result(result), .pa(pa),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .stat_msr(msr), .stat_tear(tear)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  // memory model: ready with random stalls, driven away from the active edge
  always @(negedge clk) begin
    mem_ready = mem_valid && (($urandom % 4) != 0);
    mem_rdata = rd(mem_addr);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (pend && (!mem_valid || mem_addr != pend_addr || mem_we != pend_we)) viol++;
      pend      = mem_valid && !mem_ready;
      pend_addr = mem_addr;
      pend_we   = mem_we;
      if (mem_valid && mem_ready) begin
        hs_cnt++;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt++;
        end
      end
    end else begin
      pend = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // reference model of one walk, from the requirements
  task automatic predict(input logic [31:0] va, input logic user, input logic wr,
                         input logic [3:0] bs, input logic dbg, input logic vld,
                         output logic [1:0] e_res, output logic [31:0] e_pa, output logic byp,
                         output logic [31:0] a1, output logic [31:0] e1,
                         output logic reach2, output logic [31:0] a2, output logic [31:0] e2);
    logic [31:0] base, p1, p2;
    logic        we, pr;
    logic [1:0]  need;
    byp = user ? !en_user : !en_sup;
    e_pa = va; e_res = 2'd0; a1 = 0; e1 = 0; a2 = 0; e2 = 0; reach2 = 0;
    if (!byp) begin
      base = ((dual && user) ? base1 : base0) & 32'hFFFF_F000;
      we   = wr || (bs == 4'hB);
      need = {user && !ovr, we};
      if (!dbg && !vld) exp_msr = 8'd0;
      a1 = base | {20'd0, va[31:22], 2'b00};
      p1 = rd(a1); e1 = p1;
      pr = need > p1[2:1];
      if (pr || !p1[0]) begin
        e_res = (vld && p1[0]) ? 2'd2 : 2'd1;
        if (!dbg && !vld) begin
          exp_msr  = {bs, user, wr, pr ? 2'd3 : 2'd1};
          exp_tear = va;
        end
      end else begin
        if (!dbg) e1 = p1 | 32'h80;
        reach2 = 1;
        a2 = {p1[31:12], 12'd0} | {20'd0, va[21:12], 2'b00};
        p2 = rd(a2); e2 = p2;
        pr = need > p2[2:1];
        if (pr || !p2[0]) begin
          e_res = vld ? 2'd2 : 2'd1;
          if (!dbg && !vld) begin
            exp_msr  = {bs, user, wr, pr ? 2'd3 : 2'd2};
            exp_tear = va;
          end
        end else begin
          e_pa = {p2[31:12], va[11:0]};
          if (!dbg) e2 = p2 | 32'h80 | (wr ? 32'h100 : 32'h0);
        end
      end
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic user, input logic wr,
                      input logic [3:0] bs, input logic dbg, input logic vld, input string tag);
    logic [1:0]  e_res;
    logic [31:0] e_pa, a1, e1, a2, e2;
    logic        byp, reach2;
    int          guard;
    string       stag;
    predict(va, user, wr, bs, dbg, vld, e_res, e_pa, byp, a1, e1, reach2, a2, e2);
    @(negedge clk);
    req_va = va; req_user = user; req_write = wr; req_bstat = bs;
    req_debug = dbg; req_validate = vld; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check({tag, " result"}, {30'd0, result}, {30'd0, e_res});
    if (e_res == 2'd0) check({tag, " pa"}, pa, e_pa);
    stag = byp ? "R1" : dbg ? "R11" : vld ? "R10" : (e_res != 2'd0) ? "R6" : "R7";
    check({stag, " msr"}, {24'd0, msr}, {24'd0, exp_msr});
    check({stag, " tear"}, tear, exp_tear);
    if (!byp) check(dbg ? "R11 l1 entry" : "R8 l1 entry", rd(a1), e1);
    if (reach2) check(dbg ? "R11 l2 entry" : "R9 l2 entry", rd(a2), e2);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ent(input logic [19:0] frame, input logic [11:0] low);
    return {frame, low};
  endfunction

  task automatic set_walk(input logic [31:0] base, input logic [31:0] va,
                          input logic [31:0] p1, input logic [31:0] p2);
    mem[base | {20'd0, va[31:22], 2'b00}] = p1;
    mem[{p1[31:12], 12'd0} | {20'd0, va[21:12], 2'b00}] = p2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int h0, w0;
    void'($urandom(32'h00C0_FFEE));
    rst_n = 1'b0; req_valid = 0; req_va = 0; req_user = 0; req_write = 0;
    req_bstat = 0; req_debug = 0; req_validate = 0;
    en_user = 1; en_sup = 1; dual = 0; ovr = 0; base0 = BASE_A; base1 = BASE_B;
    mem_ready = 0; mem_rdata = 0;
    exp_msr = 8'd0; exp_tear = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check("R13 busy", {31'd0, busy}, 32'd0);
    check("R13 done", {31'd0, done}, 32'd0);
    check("R13 mem_valid", {31'd0, mem_valid}, 32'd0);
    check("R13 msr", {24'd0, msr}, 32'd0);
    check("R13 tear", tear, 32'd0);

    // R1 bypass, user and supervisor
    set_walk(BASE_A, 32'h0040_5123, ent(20'h150, 12'h186), ent(20'h444, 12'h186));
    walk(32'h0040_5123, 0, 0, 4'h8, 0, 0, "R7");   // fault sets status first
    h0 = hs_cnt;
    en_user = 0;
    walk(32'h0040_5123, 1, 1, 4'hA, 0, 0, "R1");
    en_user = 1; en_sup = 0;
    walk(32'h0812_3FFF, 0, 0, 4'h8, 0, 0, "R1");
    en_sup = 1;
    check("R1 no memory access", hs_cnt - h0, 0);

    // R2 base selection and masking
    set_walk(BASE_A, 32'h0080_2ABC, ent(20'h120, 12'h087), ent(20'h777, 12'h0FF));
    set_walk(BASE_B, 32'h0080_2ABC, ent(20'h130, 12'h087), ent(20'h555, 12'h0FF));
    dual = 1;
    walk(32'h0080_2ABC, 1, 0, 4'hA, 0, 0, "R2");
    walk(32'h0080_2ABC, 0, 0, 4'hA, 0, 0, "R2");
    dual = 0;
    walk(32'h0080_2ABC, 1, 0, 4'hA, 0, 0, "R2");
    base0 = 32'h0000_1ABC;
    walk(32'h0080_2ABC, 0, 0, 4'hA, 0, 0, "R2");
    base0 = BASE_A;

    // R3 translation of a full address
    set_walk(BASE_A, 32'h00C0_3FFF, ent(20'h121, 12'h187), ent(20'hABCDE, 12'h187));
    walk(32'h00C0_3FFF, 1, 1, 4'hA, 0, 0, "R3");

    // R4 access level
    set_walk(BASE_A, 32'h0100_4010, ent(20'h140, 12'h187), ent(20'h600, 12'h181));
    walk(32'h0100_4010, 0, 0, 4'hA, 0, 0, "R4");   // level 0 read ok
    walk(32'h0100_4010, 0, 1, 4'hA, 0, 0, "R4");   // write needs 1
    walk(32'h0100_4010, 1, 0, 4'hA, 0, 0, "R4");   // user read needs 2
    ovr = 1;
    walk(32'h0100_4010, 1, 0, 4'hA, 0, 0, "R4");   // override: level 0 ok
    ovr = 0;
    walk(32'h0100_4010, 0, 0, 4'hB, 0, 0, "R4");   // RMW code counts as write
    check("R4 write flag from req only", {31'd0, msr[2]}, 32'd0);

    // R5 codes and priority
    set_walk(BASE_A, 32'h0140_0000, ent(20'h141, 12'h186), ent(20'h601, 12'h187));
    walk(32'h0140_0000, 0, 0, 4'h8, 0, 0, "R5");
    check("R5 invalid level 1 code", {30'd0, msr[1:0]}, 32'd1);
    set_walk(BASE_A, 32'h0180_0000, ent(20'h142, 12'h180), ent(20'h602, 12'h187));
    walk(32'h0180_0000, 1, 0, 4'h8, 0, 0, "R5");
    check("R5 protection priority", {30'd0, msr[1:0]}, 32'd3);
    set_walk(BASE_A, 32'h01C0_1000, ent(20'h143, 12'h187), ent(20'h603, 12'h186));
    walk(32'h01C0_1000, 1, 1, 4'h9, 0, 0, "R6");
    check("R5 invalid level 2 code", {30'd0, msr[1:0]}, 32'd2);

    // R8 / R9 write-back
    set_walk(BASE_A, 32'h0200_2000, ent(20'h144, 12'h007), ent(20'h604, 12'h087));
    walk(32'h0200_2000, 0, 1, 4'hA, 0, 0, "R9");
    w0 = wr_cnt;
    walk(32'h0200_2000, 0, 0, 4'hA, 0, 0, "R9");
    check("R9 no write when bits set", wr_cnt - w0, 0);

    // R10 validate
    set_walk(BASE_A, 32'h0240_0000, ent(20'h145, 12'h181), ent(20'h605, 12'h187));
    walk(32'h0240_0000, 1, 0, 4'h8, 0, 1, "R10");   // L1 valid prot -> cancel
    set_walk(BASE_A, 32'h0280_0000, ent(20'h146, 12'h186), ent(20'h606, 12'h187));
    walk(32'h0280_0000, 0, 0, 4'h8, 0, 1, "R10");   // L1 invalid -> abort
    set_walk(BASE_A, 32'h02C0_0000, ent(20'h147, 12'h187), ent(20'h607, 12'h186));
    walk(32'h02C0_0000, 0, 1, 4'h8, 0, 1, "R10");   // L2 fault -> cancel

    // R11 debug
    set_walk(BASE_A, 32'h0300_5000, ent(20'h148, 12'h007), ent(20'h608, 12'h007));
    w0 = wr_cnt;
    walk(32'h0300_5000, 0, 1, 4'hA, 1, 0, "R11");
    walk(32'h0280_0000, 0, 0, 4'hA, 1, 0, "R11");
    check("R11 no writes", wr_cnt - w0, 0);

    // random walks
    for (int i = 0; i < 300; i++) begin
      logic [31:0] va;
      logic [9:0]  i1, i2;
      i1 = 10'($urandom % 4); i2 = 10'($urandom % 4);
      va = {i1, i2, 12'($urandom)};
      mem[BASE_A | {20'd0, i1, 2'b00}] = {20'h100 + 20'(i1), 12'($urandom) | (($urandom % 4 != 0) ? 12'h1 : 12'h0)};
      mem[BASE_B | {20'd0, i1, 2'b00}] = {20'h200 + 20'(i1), 12'($urandom) | (($urandom % 4 != 0) ? 12'h1 : 12'h0)};
      mem[{20'h100 + 20'(i1), 12'd0} | {20'd0, i2, 2'b00}] = $urandom | (($urandom % 4 != 0) ? 32'h1 : 32'h0);
      mem[{20'h200 + 20'(i1), 12'd0} | {20'd0, i2, 2'b00}] = $urandom | (($urandom % 4 != 0) ? 32'h1 : 32'h0);
      en_user = ($urandom % 8) != 0;
      en_sup  = ($urandom % 8) != 0;
      dual    = $urandom % 2;
      ovr     = ($urandom % 4) == 0;
      walk(va, 1'($urandom), 1'($urandom), (($urandom % 4) == 0) ? 4'hB : 4'($urandom),
           ($urandom % 8) == 0, ($urandom % 6) == 0, "R3");
    end

    check("R12 request held while stalled", viol, 0);
    finish_run();
  end

endmodule